// File: doc/BRIEF.md
# Synchronized Output Flash Generator

This block produces the on/off commands for eight low-side output stages, split into two nibbles that are configured separately. Each stage starts from a bit in a bus-written output latch. A per-stage pulse-enable bit can gate that bit with a slow square wave, which makes the stage flash.

The square wave comes from an external flash clock that is much slower than the system clock. The flash clock is resampled into the system clock domain, and its rising edges are detected. Each nibble then divides those edges by its own selectable ratio.

A nibble left in input mode never drives its stages. A shutdown flag, raised on overtemperature or low supply, turns every stage off at once. The result is registered, so all stages switch on the same system clock edge.

Top module: `flash_out_gen`

## Requirements
- R1: `flash_clk_i` is resampled through two system-clock flops. With divide select 00, a nibble's flash wave equals the resampled level, so it follows the flash clock a few cycles later.
- R2: Each nibble's 2-bit select (bit 1, bit 0) picks the flash wave as follows: 00 gives the resampled level, 01 gives divide by 2, 10 gives divide by 4, and 11 gives divide by 16. The divided waves are bits 0, 1 and 3 of a counter that advances on each resampled rising edge.
- R3: `flash_sel_i[1:0]` controls stages 3..0 and `flash_sel_i[3:2]` controls stages 7..4. The two nibbles use their selects independently.
- R4: A stage with its pulse-enable bit set, in an output-mode nibble, is on only when its latch bit is 1 and its nibble's flash wave is high.
- R5: A stage with its pulse-enable bit clear, in an output-mode nibble, follows its latch bit (1 = on).
- R6: `out_mode_i[0]` (stages 3..0) and `out_mode_i[1]` (stages 7..4) set the nibble mode: 1 = output, 0 = input. All stages of an input-mode nibble are off.
- R7: While `shutdown_i` is 1, every stage is off one clock later. Normal operation returns one clock after `shutdown_i` falls.
- R8: `rst_ni` low clears the outputs at once and clears both divider counters. After release, the counters restart from zero.
- R9: The divider counters wrap modulo 16. After 16 rising edges, the divided waves repeat.
- R10: `drive_on_o[i]` = 1 turns stage i on (pin pulled low). Outputs change only on the system clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the flash clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flash_clk_i | input | 1 | Slow external flash clock, asynchronous |
| out_latch_i | input | 8 | Output latch bits, 1 = stage on |
| pulse_en_i | input | 8 | Per-stage flash enable |
| flash_sel_i | input | 4 | Divide selects, [1:0] lower nibble, [3:2] upper nibble |
| out_mode_i | input | 2 | Nibble mode, 1 = output; [0] lower, [1] upper |
| shutdown_i | input | 1 | Overtemperature / undervoltage shutdown |
| drive_on_o | output | 8 | Registered stage-on commands |

## Verification
The assertions assume three things about the inputs:
- every flash clock level lasts at least two system clock cycles, so each resampled rising edge is seen once and the divider counter never skips;
- the latch, enable, mode and shutdown inputs are synchronous to the system clock;
- comparisons on the output use the values of the previous cycle.

The stimulus respects these assumptions. It changes inputs only on falling clock edges, and it holds every flash clock level for six system cycles. That is longer than the resampling and output latency combined, so each check sees a settled wave.

// File: rtl/flash_out_pkg.sv
package flash_out_pkg;
  typedef enum logic [1:0] {
    DIV_1  = 2'b00,
    DIV_2  = 2'b01,
    DIV_4  = 2'b10,
    DIV_16 = 2'b11
  } div_sel_e;
endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flash_i,
  output logic level_o,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  // top bit is the edge register behind the synchronizer
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SH_W-2:0], flash_i};
  end

  assign level_o = sh_q[SYNC_STAGES-1];
  assign rise_o  = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R1: a detected edge lasts exactly one cycle
  a_r1_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/flash_div.sv
module flash_div
  import flash_out_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     level_i,
  input  logic     rise_i,
  input  div_sel_e sel_i,
  output logic     wave_o
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (rise_i) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      DIV_1:   wave_o = level_i;
      DIV_2:   wave_o = cnt_q[0];
      DIV_4:   wave_o = cnt_q[1];
      default: wave_o = cnt_q[MSB];
    endcase
  end

  a_r2_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(cnt_q));
  // R9: counter steps by one and wraps
  a_r9_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/flash_gate.sv
module flash_gate #(
  parameter int W = 4
) (
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] pulse_en_i,
  input  logic         wave_i,
  input  logic         out_mode_i,
  input  logic         shutdown_i,
  output logic [W-1:0] drive_o
);
  always_comb begin
    if (out_mode_i && !shutdown_i)
      drive_o = latch_i & (~pulse_en_i | {W{wave_i}});
    else
      drive_o = '0;
  end
endmodule

// File: rtl/flash_out_gen.sv
module flash_out_gen
  import flash_out_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int NUM_NIB     = 2,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flash_clk_i,
  input  logic [NIB_W*NUM_NIB-1:0] out_latch_i,
  input  logic [NIB_W*NUM_NIB-1:0] pulse_en_i,
  input  logic [2*NUM_NIB-1:0]   flash_sel_i,
  input  logic [NUM_NIB-1:0]     out_mode_i,
  input  logic                   shutdown_i,
  output logic [NIB_W*NUM_NIB-1:0] drive_on_o
);
  localparam int N = NIB_W * NUM_NIB;

  logic         level, rise;
  logic [N-1:0] drive_d;

  flash_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flash_i (flash_clk_i),
    .level_o (level),
    .rise_o  (rise)
  );

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    logic wave;

    flash_div #(.CNT_W(CNT_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (level),
      .rise_i  (rise),
      .sel_i   (div_sel_e'(flash_sel_i[2*g +: 2])),
      .wave_o  (wave)
    );

    flash_gate #(.W(NIB_W)) u_gate (
      .latch_i    (out_latch_i[NIB_W*g +: NIB_W]),
      .pulse_en_i (pulse_en_i[NIB_W*g +: NIB_W]),
      .wave_i     (wave),
      .out_mode_i (out_mode_i[g]),
      .shutdown_i (shutdown_i),
      .drive_o    (drive_d[NIB_W*g +: NIB_W])
    );

    a_r6_input_nibble_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_mode_i[g] |=> drive_on_o[NIB_W*g +: NIB_W] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_on_o <= '0;
    else         drive_on_o <= drive_d;
  end

  a_r7_shutdown_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> drive_on_o == '0);
  a_r4_no_latch_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_latch_i == '0) |=> drive_on_o == '0);
  a_r5_static_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutdown_i && (&out_mode_i) && pulse_en_i == '0) |=> drive_on_o == $past(out_latch_i));
  a_r10_drive_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drive_on_o & ~$past(out_latch_i)) == '0);
endmodule

// File: tb/tb_flash_out_gen.sv
module tb_flash_out_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;
  localparam int NV         = 14;

  typedef struct packed {
    logic [3:0] pulses;
    logic       lvl;
    logic [7:0] latch;
    logic [7:0] pen;
    logic [1:0] mode;
    logic [3:0] sel;   // {upper, lower}
    logic       sd;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // running rising-edge count noted at the end of each row
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 8'hFF, 8'h00, 2'b11, 4'b0000, 1'b0, 8'hFF, 4'd5},  // R5 n=0
    '{4'd0, 1'b1, 8'hFF, 8'hFF, 2'b11, 4'b0000, 1'b0, 8'hFF, 4'd1},  // R1 n=1 high
    '{4'd0, 1'b0, 8'hFF, 8'hFF, 2'b11, 4'b0000, 1'b0, 8'h00, 4'd1},  // R1 low
    '{4'd0, 1'b0, 8'hFF, 8'hFF, 2'b11, 4'b0001, 1'b0, 8'h0F, 4'd3},  // R3 lo /2
    '{4'd1, 1'b0, 8'hFF, 8'hFF, 2'b11, 4'b0001, 1'b0, 8'h00, 4'd2},  // R2 n=2
    '{4'd0, 1'b0, 8'hFF, 8'hFF, 2'b11, 4'b1110, 1'b0, 8'h0F, 4'd2},  // R2 /4,/16
    '{4'd6, 1'b0, 8'hFF, 8'hFF, 2'b11, 4'b1110, 1'b0, 8'hF0, 4'd3},  // R3 n=8
    '{4'd0, 1'b0, 8'h5A, 8'h0F, 2'b11, 4'b1110, 1'b0, 8'h50, 4'd4},  // R4 mixed
    '{4'd0, 1'b0, 8'hFF, 8'hFF, 2'b10, 4'b1110, 1'b0, 8'hF0, 4'd6},  // R6
    '{4'd0, 1'b0, 8'hFF, 8'h00, 2'b11, 4'b1110, 1'b1, 8'h00, 4'd7},  // R7 on
    '{4'd0, 1'b0, 8'hFF, 8'h00, 2'b11, 4'b1110, 1'b0, 8'hFF, 4'd7},  // R7 off
    '{4'd8, 1'b0, 8'hF0, 8'hFF, 2'b11, 4'b1111, 1'b0, 8'h00, 4'd9},  // R9 n=16
    '{4'd8, 1'b0, 8'hF0, 8'hFF, 2'b11, 4'b1111, 1'b0, 8'hF0, 4'd9},  // R9 n=24
    '{4'd1, 1'b0, 8'h3C, 8'h0F, 2'b11, 4'b0001, 1'b0, 8'h3C, 4'd4}   // R4 n=25
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flash = 1'b0;
  logic [7:0] latch = '0, pen = '0;
  logic [3:0] sel = '0;
  logic [1:0] mode = '0;
  logic       sd = 1'b0;
  logic [7:0] drive;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_out_gen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .flash_clk_i (flash),
    .out_latch_i (latch),
    .pulse_en_i  (pen),
    .flash_sel_i (sel),
    .out_mode_i  (mode),
    .shutdown_i  (sd),
    .drive_on_o  (drive)
  );

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] exp, input string req);
    vectors++;
    if (drive !== exp) begin
      miscompares++;
      $display("FAIL %s: drive_on_o=%h expected %h", req, drive, exp);
    end
  endtask

  task automatic pulse();
    flash = 1'b1; settle();
    flash = 1'b0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(8'h00, "R8");  // held in reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      latch = VECS[i].latch; pen = VECS[i].pen; mode = VECS[i].mode;
      sel = VECS[i].sel; sd = VECS[i].sd; flash = 1'b0;
      settle();
      for (int p = 0; p < int'(VECS[i].pulses); p++) pulse();
      if (VECS[i].lvl) begin flash = 1'b1; settle(); end
      check(VECS[i].exp, $sformatf("R%0d", VECS[i].req));
    end
    // R8: asynchronous clear and counter restart (n=25 -> bit0 set before reset)
    latch = 8'hFF; pen = 8'hFF; mode = 2'b11; sel = 4'b0101; sd = 1'b0; flash = 1'b0;
    settle();
    check(8'hFF, "R2");
    #1 rst_n = 1'b0;
    #1 check(8'h00, "R8");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check(8'h00, "R8");  // counters back to zero
    pulse();
    check(8'hFF, "R2");
    // R10: latency of one clock for a static change
    pen = 8'h00; latch = 8'h81;
    @(posedge clk); #1;
    check(8'h81, "R10");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: drive_on_o=%h expected completion", drive);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule